// File: doc/BRIEF.md
# DMA Channel Control and Completion Registers

This block holds the software-visible control and status state for every channel of a multi-channel DMA controller. A processor reaches it through a simple register port. Each channel has its own 256-byte window, selected by the upper address bits. The block turns register writes into a per-channel run enable for the transfer engine. It counts down the remaining length as the engine reports finished beats, and it raises a level interrupt when the engine signals completion.

The start bit is sticky. After a transfer completes, the run enable drops, but the start bit keeps reading 1. A fresh transfer needs a write of 0 and then a write of 1. A pending interrupt is cleared only by writing to a separate acknowledge register, and that register always reads as zero. One extra window, placed just after the last channel's window, gathers all the pending flags into a single global status word.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every run enable and interrupt output is low. The programmed count, start bit, remaining length and pending flag of every channel read 0.
- R2: A write of 1 to the start register (offset 0x18, bit 0) while that bit reads 0 does two things from the next cycle on: it sets run enable, and it loads the remaining length from the count register (offset 0x00, low LEN_W bits).
- R3: A completion pulse on a running channel has three effects from the next cycle on: run enable goes low, the interrupt goes high, and the start bit still reads 1.
- R4: A write of 1 to the start register while it already reads 1 has no effect. It does not restart the channel and does not reload the remaining length. A write of 0 followed by a write of 1 does restart the channel.
- R5: A write of 0 to the start register stops the channel: run enable goes low, and the start bit reads 0. The remaining length keeps its value.
- R6: The status register (offset 0x1C, bit 0) reads the channel's pending interrupt. The global status word (window index NCH, offset 0x00) reads this same flag in bit position equal to the channel index.
- R7: A write with bit 0 set to the acknowledge register (offset 0x20) clears the pending interrupt. A write with bit 0 clear has no effect.
- R8: A read of the acknowledge register always returns 0.
- R9: The remaining length (offset 0x24) drops by one for each beat pulse while the channel runs. It does not go below 0. Beat pulses on a stopped channel are ignored.
- R10: If a completion on a running channel arrives in the same cycle as an acknowledge write, the interrupt stays pending.
- R11: Read data appears on the cycle after the read request, marked by a one-cycle valid strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address: bits AW-1:8 select the window, bits 7:0 the offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| done_pulse | input | NCH | Per-channel completion pulse from the transfer engine |
| beat_pulse | input | NCH | Per-channel beat-finished pulse from the transfer engine |
| irq | output | NCH | Per-channel level interrupt request |
| run_en | output | NCH | Per-channel run enable to the transfer engine |

## Verification
The assertions assume the following about the inputs:
- A read and a write never share a cycle.
- The transfer engine pulses done or beat only for a channel whose run enable is high.
- The window index stays within the NCH channel windows plus the global window.

The bench keeps to these assumptions. Its stub engine issues beats and completions only after it has seen run enable. Register accesses are issued one at a time from tasks. The one stray beat it sends on purpose goes to a stopped channel, where the design is required to ignore it.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH   = 4,
  parameter int LEN_W = 16,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_rvalid,
  input  logic [NCH-1:0] done_pulse,
  input  logic [NCH-1:0] beat_pulse,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] run_en
);
  localparam int CW = AW - 8;
  localparam logic [7:0] OFS_COUNT = 8'h00;
  localparam logic [7:0] OFS_START = 8'h18;
  localparam logic [7:0] OFS_STAT  = 8'h1C;
  localparam logic [7:0] OFS_ACK   = 8'h20;
  localparam logic [7:0] OFS_REM   = 8'h24;

  wire [CW-1:0] win = reg_addr[AW-1:8];
  wire [7:0]    ofs = reg_addr[7:0];

  logic [NCH-1:0][LEN_W-1:0] cnt_v, rem_v;
  logic [NCH-1:0]            start_v, run_v, pend_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LEN_W-1:0] cnt_q, rem_q;
    logic             start_q, run_q, pend_q;
    wire wsel   = reg_wr && (win == CW'(c));
    wire ack_wr = wsel && (ofs == OFS_ACK) && reg_wdata[0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        rem_q   <= '0;
        start_q <= 1'b0;
        run_q   <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        if (wsel && ofs == OFS_COUNT) cnt_q <= reg_wdata[LEN_W-1:0];
        if (run_q && beat_pulse[c] && rem_q != '0) rem_q <= rem_q - 1'b1;
        if (wsel && ofs == OFS_START) begin
          start_q <= reg_wdata[0];
          if (reg_wdata[0] && !start_q) begin
            run_q <= 1'b1;
            rem_q <= cnt_q;
          end else if (!reg_wdata[0]) begin
            run_q <= 1'b0;
          end
        end
        if (run_q && done_pulse[c]) begin
          run_q  <= 1'b0;
          pend_q <= 1'b1;
        end else if (ack_wr) begin
          pend_q <= 1'b0;
        end
      end
    end

    assign cnt_v[c]   = cnt_q;
    assign rem_v[c]   = rem_q;
    assign start_v[c] = start_q;
    assign run_v[c]   = run_q;
    assign pend_v[c]  = pend_q;
  end

  assign irq    = pend_v;
  assign run_en = run_v;

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (win == CW'(NCH) && ofs == OFS_COUNT) rd_mux[NCH-1:0] = pend_v;
    for (int i = 0; i < NCH; i++) begin
      if (win == CW'(i)) begin
        case (ofs)
          OFS_COUNT: rd_mux[LEN_W-1:0] = cnt_v[i];
          OFS_START: rd_mux[0] = start_v[i];
          OFS_STAT:  rd_mux[0] = pend_v[i];
          OFS_REM:   rd_mux[LEN_W-1:0] = rem_v[i];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [AW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [DW-1:0]  reg_rdata,
  input logic           reg_rvalid,
  input logic [NCH-1:0] done_pulse,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] run_en
);
  localparam int CW = AW - 8;
  wire [CW-1:0] win = reg_addr[AW-1:8];
  wire [7:0]    ofs = reg_addr[7:0];

  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R11
  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && ofs == 8'h20 |=> reg_rdata == '0); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_DONE_STOPS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse[c] && run_en[c] |=> irq[c] && !run_en[c]); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && win == CW'(c) && ofs == 8'h20 && reg_wdata[0] && !done_pulse[c] |=> !irq[c]); // R7
    AST_DONE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && win == CW'(c) && ofs == 8'h20 && done_pulse[c] && run_en[c] |=> irq[c]); // R10
    AST_STATUS_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && win == CW'(c) && ofs == 8'h1C |=> reg_rdata[0] == $past(irq[c])); // R6
    AST_STOP_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && win == CW'(c) && ofs == 8'h18 && !reg_wdata[0] |=> !run_en[c]); // R5
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
  .done_pulse(done_pulse), .irq(irq), .run_en(run_en));

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  localparam int NCH = 4, LEN_W = 16, AW = 12, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic reg_rvalid;
  logic [NCH-1:0] done_pulse = '0, beat_pulse = '0, irq, run_en;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dma_chan_regs #(.NCH(NCH), .LEN_W(LEN_W), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .done_pulse(done_pulse), .beat_pulse(beat_pulse), .irq(irq), .run_en(run_en));

  function automatic logic [AW-1:0] ad(int ch, int ofs);
    return AW'((ch << 8) | ofs);
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int ofs, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad(ch, ofs); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(int ch, int ofs, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ad(ch, ofs);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic beats(int ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); beat_pulse[ch] = 1'b1;
      @(negedge clk); beat_pulse[ch] = 1'b0;
    end
  endtask

  task automatic done(int ch);
    @(negedge clk); done_pulse[ch] = 1'b1;
    @(negedge clk); done_pulse[ch] = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual unexpected read data %0h expected none", reg_rdata);
      end else begin
        string t;
        logic [DW-1:0] e;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, reg_rdata, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 run_en", DW'(run_en), 0);
    check("R1 irq", DW'(irq), 0);
    rd_expect(0, 'h24, 0, "R1 remaining");
    rd_expect(0, 'h18, 0, "R1 start");
    rd_expect(0, 'h00, 0, "R1 count");

    wr(0, 'h00, 5);
    wr(0, 'h18, 1);
    check("R2 run_en", DW'(run_en[0]), 1);
    rd_expect(0, 'h24, 5, "R2 remaining load");

    beats(0, 2);
    rd_expect(0, 'h24, 3, "R9 decrement");
    beats(0, 5);
    rd_expect(0, 'h24, 0, "R9 floor at zero");

    done(0);
    check("R3 run_en low", DW'(run_en[0]), 0);
    check("R3 irq high", DW'(irq[0]), 1);
    rd_expect(0, 'h18, 1, "R3 start sticky");
    rd_expect(0, 'h1C, 1, "R6 status");
    rd_expect(NCH, 'h00, 1, "R6 global");
    rd_expect(0, 'h20, 0, "R8 ack reads zero");
    rd_expect(0, 'h30, 0, "R11 unmapped");

    wr(0, 'h20, 0);
    check("R7 ack zero no effect", DW'(irq[0]), 1);
    wr(0, 'h20, 1);
    check("R7 ack clears", DW'(irq[0]), 0);
    rd_expect(0, 'h1C, 0, "R6 status cleared");

    wr(0, 'h00, 7);
    wr(0, 'h18, 1);
    check("R4 rewrite no start", DW'(run_en[0]), 0);
    rd_expect(0, 'h24, 0, "R4 no reload");
    wr(0, 'h18, 0);
    wr(0, 'h18, 1);
    check("R4 restart", DW'(run_en[0]), 1);
    rd_expect(0, 'h24, 7, "R4 reload");

    wr(0, 'h18, 0);
    check("R5 stop", DW'(run_en[0]), 0);
    rd_expect(0, 'h18, 0, "R5 start reads 0");
    beats(0, 1);
    rd_expect(0, 'h24, 7, "R9 beat ignored when stopped");

    wr(1, 'h00, 3);
    wr(1, 'h18, 1);
    check("R2 ch1 run", DW'(run_en[1]), 1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad(1, 'h20); reg_wdata = 1; done_pulse[1] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; done_pulse[1] = 1'b0;
    check("R10 completion wins", DW'(irq[1]), 1);
    check("R10 other channel", DW'(irq[0]), 0);
    rd_expect(NCH, 'h00, 2, "R6 global ch1");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: actual %0d reads pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule